// File: doc/BRIEF.md
# Cascaded Master, Serial-Bit and Sample-Rate Enable Generator

This block turns a single fast input clock into three clock-enable streams for a multi-channel converter interface. A first stage divides the input clock by 1, 2, 3, 4 or 5 to produce an internal-rate enable. Two further dividers count only the cycles in which that enable is high. One produces a serial-bit enable at 1, 2, 4 or 8 internal periods. The other produces a once-per-sample strobe at 256, 512, 1024 or 2048 internal periods. No derived clock is created: every output is a pulse one input clock cycle wide, and all logic stays on the single input clock.

Each rate comes from a select input, which in a full chip is a register field. A new select takes effect only at a period boundary, so no period is ever shortened or stretched. The master stage picks up its select when its own count wraps. The serial and sample stages pick up their selects only on the sample strobe, and the serial counter restarts there. As a result, every sample frame holds a whole number of serial periods, and the sample strobe always falls on a serial enable. After reset the three stages run at ÷1, ÷8 and ÷2048, whatever the select inputs carry, until their first reload point.

The design has three parts: a master counter with a variable limit, and two instances of a power-of-two divider that compare against a shifted all-ones mask.

Top module: `ctg_timing_gen`

## Requirements
- R1: `mdiv_sel` selects the master ratio as follows: 000 gives ÷1, 001 gives ÷2, 010 gives ÷3, 011 gives ÷4 and 100 gives ÷5. The values 101, 110 and 111 also give ÷1.
- R2: `imclk_en` is a pulse one clock cycle wide that repeats every N clock cycles, where N is the master ratio. At ÷1 it stays high on every cycle.
- R3: `sclk_sel` selects the serial ratio in internal periods as follows: 00 gives ÷8, 01 gives ÷4, 10 gives ÷2 and 11 gives ÷1. `sclk_en` therefore repeats every master ratio × serial ratio clock cycles, and it is high only in cycles where `imclk_en` is high.
- R4: `srate_sel` selects the sample ratio in internal periods as follows: 00 gives ÷2048, 01 gives ÷1024, 10 gives ÷512 and 11 gives ÷256. `sample_stb` repeats every master ratio × sample ratio clock cycles.
- R5: Asynchronous reset, active low on `rst_n`, sets the three stages to ÷1, ÷8 and ÷2048 regardless of the select inputs. With the master select at ÷1, `imclk_en` is high in the first cycle after release, the first `sclk_en` comes 7 cycles later, and the first `sample_stb` comes 2047 cycles later.
- R6: The master stage loads a changed `mdiv_sel` only in a cycle where `imclk_en` is high. A master period already in progress completes at its old length.
- R7: `sclk_sel` and `srate_sel` are loaded only in a cycle where `sample_stb` is high, and the serial counter restarts at that point. The frame in progress keeps its old length and its old serial rate.
- R8: Every `sample_stb` pulse coincides with an `sclk_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdiv_sel | input | 3 | Master divide select |
| sclk_sel | input | 2 | Serial-bit rate select |
| srate_sel | input | 2 | Sample-rate select |
| imclk_en | output | 1 | Internal-rate enable pulse |
| sclk_en | output | 1 | Serial-bit enable pulse |
| sample_stb | output | 1 | Once-per-sample strobe |

## Verification
The assertions rely on the select inputs being ordinary synchronous signals that stay stable around the clock edge. They do not rely on the selects being held constant, because each stage samples its select only at its own reload edge and is checked to keep its stored select everywhere else.

The bench changes selects only on the falling clock edge. It changes them both at steady points and in the middle of a period, which covers the hold-until-boundary requirements. The selects sweep every master code, including the three unused ones, and every serial and sample code.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    localparam int MDIV_SEL_W   = 3;
    localparam int MDIV_MAX_LIM = 4;
    localparam int MDIV_CNT_W   = $clog2(MDIV_MAX_LIM + 1);

    // terminal count for a master select: code n gives divide-by-(n+1); unused codes fall back to divide-by-one
    function automatic logic [MDIV_CNT_W-1:0] mdiv_limit(input logic [MDIV_SEL_W-1:0] sel);
        if (int'(sel) <= MDIV_MAX_LIM)
            return MDIV_CNT_W'(sel);
        else
            return '0;
    endfunction
endpackage

// File: rtl/ctg_master_div.sv
module ctg_master_div
    import ctg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MDIV_SEL_W-1:0] sel,
    output logic                  tick
);
    logic [MDIV_CNT_W-1:0] cnt_q;
    logic [MDIV_CNT_W-1:0] lim_q;

    always_comb begin
        tick = (cnt_q == lim_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            lim_q <= mdiv_limit(sel);
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_MCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= lim_q); // R2
    AST_MLIM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) int'(lim_q) <= MDIV_MAX_LIM); // R1
    AST_MLIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(lim_q)); // R6
endmodule

// File: rtl/ctg_pow2_div.sv
module ctg_pow2_div #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             reload,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] lim;

    // select 0 is the slowest ratio (2**CNT_W); each step up halves it
    always_comb begin
        lim   = ALL_ONES >> sel_q;
        pulse = step && (cnt_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (reload) begin
            cnt_q <= '0;
            sel_q <= sel;
        end else if (pulse) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= lim); // R4
    AST_PSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !reload |=> $stable(sel_q)); // R7
    AST_RELOAD_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n) reload |-> step); // R7
endmodule

// File: rtl/ctg_timing_gen.sv
module ctg_timing_gen #(
    parameter int SCLK_SEL_W      = 2,
    parameter int SRATE_SEL_W     = 2,
    parameter int SRATE_BASE_LOG2 = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ctg_pkg::MDIV_SEL_W-1:0]  mdiv_sel,
    input  logic [SCLK_SEL_W-1:0]           sclk_sel,
    input  logic [SRATE_SEL_W-1:0]          srate_sel,
    output logic                            imclk_en,
    output logic                            sclk_en,
    output logic                            sample_stb
);
    localparam int SCLK_CNT_W  = (2 ** SCLK_SEL_W) - 1;
    localparam int SRATE_CNT_W = SRATE_BASE_LOG2 + (2 ** SRATE_SEL_W) - 1;

    logic stb_w;

    ctg_master_div u_master (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (mdiv_sel),
        .tick  (imclk_en)
    );

    // the sample divider reloads on its own wrap
    ctg_pow2_div #(.SEL_W(SRATE_SEL_W), .CNT_W(SRATE_CNT_W)) u_srate (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (imclk_en),
        .reload (stb_w),
        .sel    (srate_sel),
        .pulse  (stb_w)
    );

    // the serial divider reloads and restarts on the frame strobe, keeping it in phase
    ctg_pow2_div #(.SEL_W(SCLK_SEL_W), .CNT_W(SCLK_CNT_W)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (imclk_en),
        .reload (stb_w),
        .sel    (sclk_sel),
        .pulse  (sclk_en)
    );

    assign sample_stb = stb_w;

    initial begin
        AST_FRAME_COVERS_SERIAL: assert (SRATE_CNT_W >= SCLK_CNT_W); // R8
    end

    AST_STB_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |-> sclk_en); // R8
    AST_SCLK_ON_IMCLK: assert property (@(posedge clk) disable iff (!rst_n) sclk_en |-> imclk_en); // R3
    AST_STB_ON_IMCLK: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |-> imclk_en); // R4
endmodule

// File: tb/ctg_timing_gen_tb_top.sv
module ctg_timing_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [2:0] mdiv_sel = '0;
    logic [1:0] sclk_sel = '0;
    logic [1:0] srate_sel = '0;
    logic       imclk_en, sclk_en, sample_stb;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ctg_timing_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdiv_sel   (mdiv_sel),
        .sclk_sel   (sclk_sel),
        .srate_sel  (srate_sel),
        .imclk_en   (imclk_en),
        .sclk_en    (sclk_en),
        .sample_stb (sample_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int w);
        case (w)
            0:       return imclk_en;
            1:       return sclk_en;
            default: return sample_stb;
        endcase
    endfunction

    task automatic wait_pulse(input int w);
        @(negedge clk);
        while (!sig(w)) @(negedge clk);
    endtask

    task automatic gap(input int w, output int g);
        wait_pulse(w);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sig(w));
    endtask

    function automatic int mratio(input int m);
        return (m >= 1 && m <= 4) ? m + 1 : 1;
    endfunction

    task automatic run_combo(input int m, input int s, input int f);
        int g;
        int mr;
        mr = mratio(m);
        @(negedge clk);
        mdiv_sel = 3'(m); sclk_sel = 2'(s); srate_sel = 2'(f);
        wait_pulse(2);
        wait_pulse(2);
        gap(0, g); chk("R1/R2 master period", g, mr);
        gap(1, g); chk("R3 serial period", g, mr << (3 - s));
        gap(2, g); chk("R4 sample period", g, mr << (11 - f));
        chk("R8 strobe on serial enable", int'(sclk_en), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        int g;
        int np;
        // R5: reset defaults override the fast selects on the inputs
        mdiv_sel = 3'd0; sclk_sel = 2'd3; srate_sel = 2'd3;
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R5 imclk_en high after release", int'(imclk_en), 1);
        chk("R5 sample_stb low after release", int'(sample_stb), 0);
        k = 0;
        while (!sclk_en) begin @(negedge clk); k++; end
        chk("R5 first serial enable", k, 7);
        while (!sample_stb) begin @(negedge clk); k++; end
        chk("R5 first sample strobe", k, 2047);
        gap(1, g); chk("R5 serial rate after first reload", g, 1);
        gap(2, g); chk("R5 sample rate after first reload", g, 256);

        // R1 R2 R3 R8: every master code against every serial code
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 4; s++)
                run_combo(m, s, 3);
        // R4: every sample code
        for (int f = 0; f < 4; f++)
            run_combo(0, f, f);
        run_combo(2, 1, 2);

        // R7: selects changed mid-frame wait for the strobe
        run_combo(0, 0, 3);
        wait_pulse(2);
        k = 0; np = 0;
        do begin
            @(negedge clk);
            k++;
            if (sclk_en) np++;
            if (k == 20) begin sclk_sel = 2'd3; srate_sel = 2'd2; end
        end while (!sample_stb);
        chk("R7 frame length held", k, 256);
        chk("R7 serial pulses in held frame", np, 32);
        gap(1, g); chk("R7 new serial rate", g, 1);
        gap(2, g); chk("R7 new sample rate", g, 512);

        // R6: master select changed mid-period waits for the wrap
        run_combo(4, 3, 3);
        wait_pulse(0);
        @(negedge clk);
        k = 1;
        mdiv_sel = 3'd1;
        while (!imclk_en) begin @(negedge clk); k++; end
        chk("R6 master period held", k, 5);
        gap(0, g); chk("R6 new master period", g, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule